// File: doc/BRIEF.md
# PWM Compare Channel with Complementary Outputs

This block is one compare channel that sits beside a shared timebase counter. Each cycle it sees the counter value and the counting direction, and it compares the counter against its active compare value. From that relation and a 3-bit mode it builds an internal reference waveform. The reference can be frozen, set, cleared or toggled on a match, forced to a fixed level, or produced as a PWM level from a less-than test that works the same when counting up or down.

The compare value is written through a small write port. With preload off, a write reaches the active register in the next cycle. With preload on, the write lands in a shadow register, and the timebase update pulse copies it into the active register. The reference drives two pins: a main pin that follows the reference, and a complementary pin that follows its inverse. Each pin has its own enable and polarity. A two-bit output mask and a global output enable can also force both pins to their inactive level.

A sticky match flag records qualified counter/compare matches and is cleared by a clear strobe. The active compare value is brought out so its load timing can be observed.

Top module: `pwm_cmp_chan`

## Requirements
- R1: While rst_ni is low and in the first cycle after it, cmp_val_o is 0, match_flag_o is 0 and the reference is 0, so with every pin gate open and polarity 0 the main pin reads 0 and the complementary pin reads 1.
- R2: A qualified match is cnt_i == cmp_val_o, further restricted by align_i: 00 and 11 accept either direction, 01 accepts only cnt_down_i=1, 10 accepts only cnt_down_i=0. The reference register updates at the clock edge after the inputs are presented.
- R3: Mode 000 holds the reference unchanged, even on a qualified match.
- R4: Mode 001 sets the reference to 1 on a qualified match, and mode 010 clears it to 0 on one. Without a match both hold.
- R5: Mode 011 inverts the reference on each cycle that has a qualified match.
- R6: Mode 100 forces the reference to 0, and mode 101 forces it to 1.
- R7: Mode 110 sets the reference to (cnt_i < cmp_val_o), and mode 111 sets it to the inverse. Both ignore cnt_down_i.
- R8: With preload_en_i=0, a write (cmp_we_i) appears on cmp_val_o one cycle later.
- R9: With preload_en_i=1, a write goes only to a shadow register, and cmp_val_o holds its value until a cycle with upd_i=1. That cycle copies the shadow into cmp_val_o.
- R10: The main pin is reference XOR main_pol_i, and the complementary pin is (NOT reference) XOR comp_pol_i. Each pin is gated by its own enable (main_en_i, comp_en_i).
- R11: A pin drives its value only when moe_i=1 and its bit of oe_mask_i is set (bit 0 main, bit 1 complementary). Otherwise it, like a disabled pin, drives 0.
- R12: match_flag_o is set one cycle after a qualified match and stays set until a cycle with flag_clr_i=1 and no qualified match clears it. If the clear strobe and a match arrive in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CNT_W | Timebase counter value |
| cnt_down_i | input | 1 | Counter is counting down |
| upd_i | input | 1 | Timebase update event pulse |
| align_i | input | 2 | Match direction qualification code |
| mode_i | input | 3 | Reference mode |
| preload_en_i | input | 1 | Compare preload (shadow) enable |
| cmp_we_i | input | 1 | Compare value write strobe |
| cmp_wdata_i | input | CNT_W | Compare value write data |
| main_en_i | input | 1 | Main pin enable |
| main_pol_i | input | 1 | Main pin polarity (1 inverts) |
| comp_en_i | input | 1 | Complementary pin enable |
| comp_pol_i | input | 1 | Complementary pin polarity (1 inverts) |
| oe_mask_i | input | 2 | Per-pin output enable, bit 0 main, bit 1 complementary |
| moe_i | input | 1 | Global output enable |
| flag_clr_i | input | 1 | Match flag clear strobe |
| out_main_o | output | 1 | Main pin level |
| out_comp_o | output | 1 | Complementary pin level |
| match_flag_o | output | 1 | Sticky qualified-match flag |
| cmp_val_o | output | CNT_W | Active compare value |

## Verification
The hardest case to reach is a preloaded compare write that must not show up until the update pulse. The stimulus writes a new value with preload on and runs several cycles without an update. It checks that the active value has not moved, then raises the update pulse and checks the new value one cycle later. The direction-qualified flag is the second difficult case. The counter is held equal to the compare value while only the direction input changes, so a wrong qualification code shows up as a flag that sets too early. The stimulus also asserts the clear strobe and a match in the same cycle to confirm that the set has priority.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;
  typedef enum logic [2:0] {
    MODE_FREEZE = 3'b000,
    MODE_SET    = 3'b001,
    MODE_CLR    = 3'b010,
    MODE_TOGGLE = 3'b011,
    MODE_LOW    = 3'b100,
    MODE_HIGH   = 3'b101,
    MODE_LT_HI  = 3'b110,
    MODE_LT_LO  = 3'b111
  } ref_mode_e;

  localparam logic [1:0] ALIGN_EDGE = 2'b00;
  localparam logic [1:0] ALIGN_DOWN = 2'b01;
  localparam logic [1:0] ALIGN_UP   = 2'b10;
  localparam logic [1:0] ALIGN_BOTH = 2'b11;

  localparam int unsigned NUM_PINS = 2;
endpackage

// File: rtl/pwm_cmp_reg.sv
module pwm_cmp_reg #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             preload_en_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             upd_i,
  output logic [CNT_W-1:0] active_o
);
  logic [CNT_W-1:0] shadow_q, active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (we_i) shadow_q <= wdata_i;
      if (!preload_en_i) begin
        if (we_i) active_q <= wdata_i;
      end else if (upd_i) begin
        active_q <= shadow_q;
      end
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/pwm_ref_gen.sv
module pwm_ref_gen
  import pwm_cmp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_down_i,
  input  logic [1:0]       align_i,
  input  logic [2:0]       mode_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             flag_clr_i,
  output logic             ref_o,
  output logic             flag_o
);
  logic eq, dir_ok, hit, below;
  logic ref_q, ref_d, flag_q;
  ref_mode_e mode;

  assign mode  = ref_mode_e'(mode_i);
  assign eq    = (cnt_i == cmp_i);
  assign below = (cnt_i < cmp_i);

  always_comb begin
    unique case (align_i)
      ALIGN_DOWN: dir_ok = cnt_down_i;
      ALIGN_UP:   dir_ok = !cnt_down_i;
      default:    dir_ok = 1'b1;
    endcase
  end

  assign hit = eq && dir_ok;

  always_comb begin
    ref_d = ref_q;
    unique case (mode)
      MODE_FREEZE: ref_d = ref_q;
      MODE_SET:    if (hit) ref_d = 1'b1;
      MODE_CLR:    if (hit) ref_d = 1'b0;
      MODE_TOGGLE: if (hit) ref_d = !ref_q;
      MODE_LOW:    ref_d = 1'b0;
      MODE_HIGH:   ref_d = 1'b1;
      MODE_LT_HI:  ref_d = below;
      MODE_LT_LO:  ref_d = !below;
      default:     ref_d = ref_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      ref_q <= ref_d;
      if (hit)             flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign ref_o  = ref_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
  import pwm_cmp_pkg::*;
(
  input  logic                ref_i,
  input  logic [NUM_PINS-1:0] en_i,
  input  logic [NUM_PINS-1:0] pol_i,
  input  logic [NUM_PINS-1:0] oe_mask_i,
  input  logic                moe_i,
  output logic [NUM_PINS-1:0] pin_o
);
  logic [NUM_PINS-1:0] src;
  assign src[0] = ref_i;
  assign src[1] = !ref_i;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic drive;
    assign drive    = moe_i && oe_mask_i[p] && en_i[p];
    assign pin_o[p] = drive ? (src[p] ^ pol_i[p]) : 1'b0;
  end
endmodule

// File: rtl/pwm_cmp_chan.sv
module pwm_cmp_chan
  import pwm_cmp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_down_i,
  input  logic             upd_i,
  input  logic [1:0]       align_i,
  input  logic [2:0]       mode_i,
  input  logic             preload_en_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic             main_en_i,
  input  logic             main_pol_i,
  input  logic             comp_en_i,
  input  logic             comp_pol_i,
  input  logic [1:0]       oe_mask_i,
  input  logic             moe_i,
  input  logic             flag_clr_i,
  output logic             out_main_o,
  output logic             out_comp_o,
  output logic             match_flag_o,
  output logic [CNT_W-1:0] cmp_val_o
);
  logic [CNT_W-1:0]    cmp_act;
  logic                ref_lvl;
  logic [NUM_PINS-1:0] pins;

  pwm_cmp_reg #(.CNT_W(CNT_W)) u_cmp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .preload_en_i (preload_en_i),
    .we_i         (cmp_we_i),
    .wdata_i      (cmp_wdata_i),
    .upd_i        (upd_i),
    .active_o     (cmp_act)
  );

  pwm_ref_gen #(.CNT_W(CNT_W)) u_ref (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_i      (cnt_i),
    .cnt_down_i (cnt_down_i),
    .align_i    (align_i),
    .mode_i     (mode_i),
    .cmp_i      (cmp_act),
    .flag_clr_i (flag_clr_i),
    .ref_o      (ref_lvl),
    .flag_o     (match_flag_o)
  );

  pwm_out_stage u_out (
    .ref_i     (ref_lvl),
    .en_i      ({comp_en_i, main_en_i}),
    .pol_i     ({comp_pol_i, main_pol_i}),
    .oe_mask_i (oe_mask_i),
    .moe_i     (moe_i),
    .pin_o     (pins)
  );

  assign out_main_o = pins[0];
  assign out_comp_o = pins[1];
  assign cmp_val_o  = cmp_act;
endmodule

// File: rtl/pwm_cmp_chan_chk.sv
module pwm_cmp_chan_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_i,
  input logic             upd_i,
  input logic [2:0]       mode_i,
  input logic             preload_en_i,
  input logic             cmp_we_i,
  input logic [CNT_W-1:0] cmp_wdata_i,
  input logic             main_en_i,
  input logic             main_pol_i,
  input logic             comp_en_i,
  input logic             comp_pol_i,
  input logic [1:0]       oe_mask_i,
  input logic             moe_i,
  input logic             out_main_o,
  input logic             out_comp_o,
  input logic             match_flag_o,
  input logic [CNT_W-1:0] cmp_val_o
);
  // R8
  direct_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_we_i && !preload_en_i) |=> (cmp_val_o == $past(cmp_wdata_i)));

  // R9
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preload_en_i && !upd_i) |=> $stable(cmp_val_o));

  // R11
  moe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !moe_i |-> (!out_main_o && !out_comp_o));

  // R10
  complement_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (moe_i && (oe_mask_i == 2'b11) && main_en_i && comp_en_i && (main_pol_i == comp_pol_i))
      |-> (out_main_o != out_comp_o));

  // R6
  forced_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) == 3'b100 && moe_i && oe_mask_i[0] && main_en_i && !main_pol_i)
      |-> !out_main_o);

  // R12
  flag_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_flag_o) |-> $past(cnt_i == cmp_val_o));
endmodule

bind pwm_cmp_chan pwm_cmp_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cnt_i        (cnt_i),
  .upd_i        (upd_i),
  .mode_i       (mode_i),
  .preload_en_i (preload_en_i),
  .cmp_we_i     (cmp_we_i),
  .cmp_wdata_i  (cmp_wdata_i),
  .main_en_i    (main_en_i),
  .main_pol_i   (main_pol_i),
  .comp_en_i    (comp_en_i),
  .comp_pol_i   (comp_pol_i),
  .oe_mask_i    (oe_mask_i),
  .moe_i        (moe_i),
  .out_main_o   (out_main_o),
  .out_comp_o   (out_comp_o),
  .match_flag_o (match_flag_o),
  .cmp_val_o    (cmp_val_o)
);

// File: tb/tb_pwm_cmp_chan.sv
module tb_pwm_cmp_chan;
  localparam int unsigned CNT_W = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [CNT_W-1:0] cnt_i = '0;
  logic             cnt_down_i = 1'b0;
  logic             upd_i = 1'b0;
  logic [1:0]       align_i = 2'b00;
  logic [2:0]       mode_i = 3'b000;
  logic             preload_en_i = 1'b0;
  logic             cmp_we_i = 1'b0;
  logic [CNT_W-1:0] cmp_wdata_i = '0;
  logic             main_en_i = 1'b1;
  logic             main_pol_i = 1'b0;
  logic             comp_en_i = 1'b1;
  logic             comp_pol_i = 1'b0;
  logic [1:0]       oe_mask_i = 2'b11;
  logic             moe_i = 1'b1;
  logic             flag_clr_i = 1'b0;
  logic             out_main_o, out_comp_o, match_flag_o;
  logic [CNT_W-1:0] cmp_val_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = !clk_i;

  pwm_cmp_chan #(.CNT_W(CNT_W)) dut (.*);

  task automatic chk(input string req, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic write_cmp(input logic [CNT_W-1:0] v);
    cmp_we_i = 1'b1; cmp_wdata_i = v;
    tick();
    cmp_we_i = 1'b0;
  endtask

  task automatic t_reset();
    tick();
    chk("R1 cmp", cmp_val_o, 0);
    chk("R1 flag", {15'd0, match_flag_o}, 0);
    chk("R1 main", {15'd0, out_main_o}, 0);
    chk("R1 comp", {15'd0, out_comp_o}, 1);
    rst_ni = 1'b1;
    tick();
    chk("R1 main after release", {15'd0, out_main_o}, 0);
  endtask

  task automatic t_direct_write();
    preload_en_i = 1'b0;
    write_cmp(16'd5);
    chk("R8 immediate write", cmp_val_o, 16'd5);
  endtask

  task automatic t_freeze_forced();
    cnt_i = 16'd1;
    mode_i = 3'b101; tick();
    chk("R6 forced high", {15'd0, out_main_o}, 1);
    mode_i = 3'b000; cnt_i = 16'd5; tick();
    chk("R3 freeze on match", {15'd0, out_main_o}, 1);
    mode_i = 3'b100; cnt_i = 16'd2; tick();
    chk("R6 forced low main", {15'd0, out_main_o}, 0);
    chk("R6 forced low comp", {15'd0, out_comp_o}, 1);
    mode_i = 3'b000; cnt_i = 16'd5; tick();
    chk("R3 freeze low on match", {15'd0, out_main_o}, 0);
  endtask

  task automatic t_set_clear();
    mode_i = 3'b001; cnt_i = 16'd3; tick();
    chk("R4 set no match", {15'd0, out_main_o}, 0);
    cnt_i = 16'd5; tick();
    chk("R4 set on match", {15'd0, out_main_o}, 1);
    mode_i = 3'b010; cnt_i = 16'd4; tick();
    chk("R4 clear no match", {15'd0, out_main_o}, 1);
    cnt_i = 16'd5; tick();
    chk("R4 clear on match", {15'd0, out_main_o}, 0);
  endtask

  task automatic t_toggle();
    mode_i = 3'b011; cnt_i = 16'd5; tick();
    chk("R5 toggle 1", {15'd0, out_main_o}, 1);
    cnt_i = 16'd6; tick();
    chk("R5 hold", {15'd0, out_main_o}, 1);
    cnt_i = 16'd5; tick();
    chk("R5 toggle 2", {15'd0, out_main_o}, 0);
  endtask

  task automatic t_pwm();
    mode_i = 3'b110; cnt_down_i = 1'b0; cnt_i = 16'd4; tick();
    chk("R7 lt_hi below up", {15'd0, out_main_o}, 1);
    cnt_i = 16'd5; tick();
    chk("R7 lt_hi equal", {15'd0, out_main_o}, 0);
    cnt_down_i = 1'b1; cnt_i = 16'd4; tick();
    chk("R7 lt_hi below down", {15'd0, out_main_o}, 1);
    cnt_i = 16'd9; tick();
    chk("R7 lt_hi above down", {15'd0, out_main_o}, 0);
    mode_i = 3'b111; cnt_i = 16'd4; tick();
    chk("R7 lt_lo below", {15'd0, out_main_o}, 0);
    cnt_down_i = 1'b0; cnt_i = 16'd7; tick();
    chk("R7 lt_lo above", {15'd0, out_main_o}, 1);
    cnt_i = 16'd0;
  endtask

  task automatic t_preload();
    preload_en_i = 1'b1;
    write_cmp(16'd20);
    chk("R9 shadow not active", cmp_val_o, 16'd5);
    tick(); tick();
    chk("R9 hold without update", cmp_val_o, 16'd5);
    upd_i = 1'b1; tick(); upd_i = 1'b0;
    chk("R9 loaded on update", cmp_val_o, 16'd20);
  endtask

  task automatic t_polarity();
    mode_i = 3'b101; tick();
    main_pol_i = 1'b1; comp_pol_i = 1'b1; tick();
    chk("R10 main inverted", {15'd0, out_main_o}, 0);
    chk("R10 comp inverted", {15'd0, out_comp_o}, 1);
    comp_en_i = 1'b0; tick();
    chk("R10 comp disabled", {15'd0, out_comp_o}, 0);
    chk("R10 main still on", {15'd0, out_main_o}, 0);
    main_pol_i = 1'b0; comp_pol_i = 1'b0; comp_en_i = 1'b1; tick();
    chk("R10 main plain", {15'd0, out_main_o}, 1);
    chk("R10 comp plain", {15'd0, out_comp_o}, 0);
  endtask

  task automatic t_gating();
    comp_pol_i = 1'b1;
    moe_i = 1'b0; tick();
    chk("R11 moe off main", {15'd0, out_main_o}, 0);
    chk("R11 moe off comp", {15'd0, out_comp_o}, 0);
    moe_i = 1'b1; oe_mask_i = 2'b01; tick();
    chk("R11 mask main on", {15'd0, out_main_o}, 1);
    chk("R11 mask comp off", {15'd0, out_comp_o}, 0);
    oe_mask_i = 2'b10; tick();
    chk("R11 mask main off", {15'd0, out_main_o}, 0);
    chk("R11 mask comp on", {15'd0, out_comp_o}, 1);
    oe_mask_i = 2'b11; comp_pol_i = 1'b0;
  endtask

  task automatic t_flag();
    cnt_i = 16'd1; flag_clr_i = 1'b1; tick(); flag_clr_i = 1'b0;
    chk("R12 cleared", {15'd0, match_flag_o}, 0);
    align_i = 2'b01; cnt_i = 16'd20; cnt_down_i = 1'b0; tick();
    chk("R2 down-only rejects up", {15'd0, match_flag_o}, 0);
    cnt_down_i = 1'b1; tick();
    chk("R2 down-only accepts down", {15'd0, match_flag_o}, 1);
    cnt_i = 16'd3; tick();
    chk("R12 sticky", {15'd0, match_flag_o}, 1);
    flag_clr_i = 1'b1; tick(); flag_clr_i = 1'b0;
    chk("R12 clear no match", {15'd0, match_flag_o}, 0);
    align_i = 2'b10; cnt_i = 16'd20; cnt_down_i = 1'b1; tick();
    chk("R2 up-only rejects down", {15'd0, match_flag_o}, 0);
    cnt_down_i = 1'b0; tick();
    chk("R2 up-only accepts up", {15'd0, match_flag_o}, 1);
    flag_clr_i = 1'b1; tick(); flag_clr_i = 1'b0;
    chk("R12 set wins over clear", {15'd0, match_flag_o}, 1);
    cnt_i = 16'd0; align_i = 2'b00;
  endtask

  initial begin
    t_reset();
    t_direct_write();
    t_freeze_forced();
    t_set_clear();
    t_toggle();
    t_pwm();
    t_preload();
    t_polarity();
    t_gating();
    t_flag();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule